// File: doc/BRIEF.md
# LIN Frame Checksum and Length Unit

This block works out how many data bytes a LIN frame carries and computes the checksum for that frame. It also checks a received checksum against it. A configuration byte sets two things: a version bit that picks classic or enhanced checksum, and a 4-bit size field. The size field either gives the data length directly or asks for the length to be decoded from the top two bits of the frame identifier.

A frame begins with a one-cycle `start` pulse. In classic mode the pulse clears the accumulator. In enhanced mode it loads the accumulator with the protected identifier (the 6-bit identifier plus two parity bits). Each accepted data byte is added in one cycle. The add is an 8-bit sum in which any carry out of bit 7 is folded back into bit 0. The inverted sum is always available as the checksum to transmit.

Once the expected number of data bytes has been taken, the next byte is treated as the received checksum. It is compared with the inverted sum, and a one-cycle done strobe marks the end of the frame. A receive path uses the match flag. A transmit path reads the final checksum instead.

Top module: `lin_csum_unit`

## Requirements
- R1: Reset clears the configuration byte to 8'h00, which means classic mode and a size field of 0. Bits 6 to 4 of the configuration readback are always 0 whatever is written. Bit 7 and bits 3 to 0 read back as written.
- R2: When the size field is 1 to 8, `data_len` equals the size field and `size_oob` is 0.
- R3: When the size field is 4'b1111, `data_len` comes from identifier bits 5:4: 00 gives 2, 01 gives 2, 10 gives 4 and 11 gives 8. `size_oob` is 0.
- R4: A size field of 0, or of 9 to 14, gives `data_len` of 8 with `size_oob` set to 1.
- R5: When configuration bit 7 is 0 (classic mode), `start` clears `run_sum` to 0 in the next cycle, so the checksum covers only the data bytes.
- R6: When configuration bit 7 is 1 (enhanced mode), `start` loads `run_sum` with the full 8-bit protected identifier in the next cycle.
- R7: Each accepted data byte is added to `run_sum` in one cycle. A carry out of bit 7 is added back into bit 0. `csum_out` is always the bitwise inverse of `run_sum`.
- R8: After `data_len` data bytes, the next accepted byte is compared with `csum_out`. In the following cycle `chk_match` is 1 if the two are equal and 0 otherwise. `chk_match` holds that value until the next `start`.
- R9: `done` is high for exactly one cycle, in the cycle after the byte that ends a frame.
- R10: A data byte that arrives with `byte_last` set ends the frame early. The byte is still added, then `done` pulses and `chk_match` is 0.
- R11: A byte offered while no frame is open is ignored, and `run_sum` does not change.
- R12: When `start` and `byte_valid` are high in the same cycle, `start` wins and the byte is not counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Write strobe for the configuration byte |
| cfg_wdata | input | 8 | Configuration write data: bit 7 is the version bit, bits 3:0 are the size field |
| cfg_rdata | output | 8 | Configuration readback |
| pid | input | 8 | Protected identifier: bits 5:0 are the identifier, bits 7:6 are parity |
| start | input | 1 | One-cycle pulse that opens a frame |
| byte_valid | input | 1 | A byte is offered on `byte_data` |
| byte_data | input | 8 | Data or checksum byte |
| byte_last | input | 1 | Marks the final byte of a frame |
| data_len | output | LEN_W | Expected data-field length, decoded from the current configuration |
| size_oob | output | 1 | The size field was out of range and has been clamped |
| run_sum | output | 8 | Running sum with end-around carry |
| csum_out | output | 8 | Inverted running sum |
| chk_match | output | 1 | The received checksum byte matched |
| done | output | 1 | One-cycle end-of-frame strobe |

## Verification
The bench builds the block with its defaults: MAX_LEN of 8 and SIZE_W of 4, so LEN_W is 4. With these values every size code from 0 to 15 maps to a reachable length, and the clamp boundary at 9 sits inside the 4-bit field. Frames of one to eight bytes, including all-0xFF data that forces a carry fold on every add, can therefore be driven in both checksum modes.

// File: rtl/lin_csum_pkg.sv
// Package: shared byte type, configuration field layout and the
// end-around-carry adder used by the checksum accumulator.
// Assumes bytes are 8 bits wide, which the checksum format fixes.
package lin_csum_pkg;
    localparam int BYTE_W = 8;
    typedef logic [BYTE_W-1:0] byte_t;

    // Bit 7 selects enhanced mode; bits 3:0 are the size field; 6:4 unused.
    localparam int    CFG_VER_BIT = 7;
    localparam byte_t CFG_MASK    = 8'h8F;

    // Frame sequencer phase.
    typedef enum logic {PH_IDLE = 1'b0, PH_OPEN = 1'b1} phase_t;

    // 8-bit add in which the carry out of the top bit is added back in.
    function automatic byte_t ec_add(input byte_t a, input byte_t b);
        logic [BYTE_W:0] t;
        t = {1'b0, a} + {1'b0, b};
        return t[BYTE_W-1:0] + {{(BYTE_W-1){1'b0}}, t[BYTE_W]};
    endfunction
endpackage

// File: rtl/lin_cfg_reg.sv
// Configuration byte register.
// Holds the version bit and the size field. Unused bits are masked on
// write, so they always read back as zero. Synchronous active-low reset.
module lin_cfg_reg
    import lin_csum_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  we,
    input  byte_t wdata,
    output byte_t cfg
);
    // Capture masked write data; reset to classic mode, size 0.
    always_ff @(posedge clk) begin
        if (!rst_n)  cfg <= '0;
        else if (we) cfg <= wdata & CFG_MASK;
    end
endmodule

// File: rtl/lin_len_decode.sv
// Data-field length decoder.
// Turns the size field and identifier bits 5:4 into a byte count.
// Out-of-range codes are clamped to MAX_LEN and flagged.
// Purely combinational; assumes MAX_LEN >= 8.
module lin_len_decode #(
    parameter int SIZE_W  = 4,
    parameter int MAX_LEN = 8,
    parameter int LEN_W   = $clog2(MAX_LEN + 1)
) (
    input  logic [SIZE_W-1:0] size,
    input  logic [1:0]        id_hi,
    output logic [LEN_W-1:0]  len,
    output logic              oob
);
    localparam logic [SIZE_W-1:0] SZ_BY_ID = '1;
    localparam logic [LEN_W-1:0]  LEN_MAX  = LEN_W'(MAX_LEN);

    // Select between identifier decode, direct value and clamp.
    always_comb begin
        oob = 1'b0;
        if (size == SZ_BY_ID) begin
            unique case (id_hi)
                2'b00, 2'b01: len = LEN_W'(2);
                2'b10:        len = LEN_W'(4);
                default:      len = LEN_W'(8);
            endcase
        end else if (size == '0 || 32'(size) > MAX_LEN) begin
            len = LEN_MAX;
            oob = 1'b1;
        end else begin
            len = LEN_W'(size);
        end
    end
endmodule

// File: rtl/lin_csum_acc.sv
// Checksum accumulator.
// Loads a seed (zero or the protected identifier) on clear, then folds
// each added byte in with end-around carry. Seed takes priority over add.
module lin_csum_acc
    import lin_csum_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  load,
    input  byte_t seed,
    input  logic  add,
    input  byte_t din,
    output byte_t sum
);
    // Seed on frame open, otherwise accumulate accepted data bytes.
    always_ff @(posedge clk) begin
        if (!rst_n)    sum <= '0;
        else if (load) sum <= seed;
        else if (add)  sum <= ec_add(sum, din);
    end
endmodule

// File: rtl/lin_frame_seq.sv
// Frame sequencer.
// Latches the length at start, counts data bytes, treats the byte after
// the last data byte as the received checksum, and ends the frame early
// on a data byte that carries the last strobe.
// Assumes start is a single-cycle pulse; start outranks a byte in the same cycle.
module lin_frame_seq
    import lin_csum_pkg::*;
#(
    parameter int LEN_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [LEN_W-1:0] len_in,
    input  logic             byte_valid,
    input  logic             byte_last,
    input  byte_t            byte_data,
    input  byte_t            expect_csum,
    output logic             add_en,
    output logic             open,
    output logic             match,
    output logic             done
);
    phase_t           phase;
    logic [LEN_W-1:0] cnt;
    logic [LEN_W-1:0] len_q;
    logic             accept;
    logic             in_data;

    assign open    = (phase == PH_OPEN);
    assign accept  = byte_valid && !start && open;
    assign in_data = (cnt < len_q);
    assign add_en  = accept && in_data;

    // Track phase, byte count, result flag and done strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= PH_IDLE;
            cnt   <= '0;
            len_q <= '0;
            match <= 1'b0;
            done  <= 1'b0;
        end else begin
            done <= 1'b0;
            if (start) begin
                phase <= PH_OPEN;
                cnt   <= '0;
                len_q <= len_in;
                match <= 1'b0;
            end else if (accept) begin
                if (in_data) begin
                    cnt <= cnt + 1'b1;
                    if (byte_last) begin
                        phase <= PH_IDLE;
                        done  <= 1'b1;
                        match <= 1'b0;
                    end
                end else begin
                    phase <= PH_IDLE;
                    done  <= 1'b1;
                    match <= (byte_data == expect_csum);
                end
            end
        end
    end

    // R9: the end strobe never lasts two cycles.
    p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R8: the data count never passes the latched length.
    p_count_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
        open |-> (cnt <= len_q));

    // R10: an early last byte closes the frame without a match.
    p_early_last_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (add_en && byte_last) |=> (done && !match && !open));
endmodule

// File: rtl/lin_csum_unit.sv
// LIN frame checksum and length unit (top).
// Combines the configuration register, length decoder, accumulator and
// frame sequencer. Classic mode seeds with zero, enhanced mode with the
// protected identifier. Synchronous active-low reset; one byte per cycle.
module lin_csum_unit
    import lin_csum_pkg::*;
#(
    parameter int SIZE_W  = 4,
    parameter int MAX_LEN = 8,
    parameter int LEN_W   = $clog2(MAX_LEN + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [7:0]       cfg_wdata,
    output logic [7:0]       cfg_rdata,
    input  logic [7:0]       pid,
    input  logic             start,
    input  logic             byte_valid,
    input  logic [7:0]       byte_data,
    input  logic             byte_last,
    output logic [LEN_W-1:0] data_len,
    output logic             size_oob,
    output logic [7:0]       run_sum,
    output logic [7:0]       csum_out,
    output logic             chk_match,
    output logic             done
);
    byte_t cfg;
    logic  enh;
    logic  add_en;
    logic  open;
    byte_t seed;

    lin_cfg_reg u_cfg (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (cfg_we),
        .wdata (cfg_wdata),
        .cfg   (cfg)
    );

    assign cfg_rdata = cfg;
    assign enh       = cfg[CFG_VER_BIT];
    assign seed      = enh ? pid : '0;

    lin_len_decode #(
        .SIZE_W  (SIZE_W),
        .MAX_LEN (MAX_LEN),
        .LEN_W   (LEN_W)
    ) u_len (
        .size  (cfg[SIZE_W-1:0]),
        .id_hi (pid[5:4]),
        .len   (data_len),
        .oob   (size_oob)
    );

    lin_csum_acc u_acc (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (start),
        .seed  (seed),
        .add   (add_en),
        .din   (byte_data),
        .sum   (run_sum)
    );

    assign csum_out = ~run_sum;

    lin_frame_seq #(.LEN_W(LEN_W)) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (start),
        .len_in      (data_len),
        .byte_valid  (byte_valid),
        .byte_last   (byte_last),
        .byte_data   (byte_data),
        .expect_csum (csum_out),
        .add_en      (add_en),
        .open        (open),
        .match       (chk_match),
        .done        (done)
    );

    // R1: one cycle of reset leaves the configuration at zero.
    p_cfg_reset_r1: assert property (@(posedge clk)
        !rst_n |=> (cfg_rdata == 8'h00));

    // R5: classic start clears the sum.
    p_classic_seed_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !enh) |=> (run_sum == 8'h00));

    // R6: enhanced start seeds the sum with the protected identifier.
    p_enh_seed_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (start && enh) |=> (run_sum == $past(pid)));

    // R11: with no frame open and no start, the sum holds.
    p_idle_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!open && !start) |=> $stable(run_sum));

    // R4: a clamp is always to the maximum length.
    p_clamp_r4: assert property (@(posedge clk) disable iff (!rst_n)
        size_oob |-> (32'(data_len) == MAX_LEN));
endmodule

// File: tb/sim_lin_csum_unit.sv
module sim_lin_csum_unit;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_we = 1'b0;
    logic [7:0] cfg_wdata = '0;
    logic [7:0] cfg_rdata;
    logic [7:0] pid = '0;
    logic       start = 1'b0;
    logic       byte_valid = 1'b0;
    logic [7:0] byte_data = '0;
    logic       byte_last = 1'b0;
    logic [3:0] data_len;
    logic       size_oob;
    logic [7:0] run_sum;
    logic [7:0] csum_out;
    logic       chk_match;
    logic       done;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    lin_csum_unit u0 (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata), .pid(pid), .start(start),
        .byte_valid(byte_valid), .byte_data(byte_data), .byte_last(byte_last),
        .data_len(data_len), .size_oob(size_oob), .run_sum(run_sum),
        .csum_out(csum_out), .chk_match(chk_match), .done(done)
    );

    // Vector: {cfg, pid, eight data bytes, first byte in the top position}
    localparam int NV = 9;
    localparam logic [79:0] VEC [NV] = '{
        {8'h04, 8'h11, 64'h4A55_93E5_0000_0000},
        {8'h84, 8'h4A, 64'h4A55_93E5_0000_0000},
        {8'h0F, 8'h25, 64'h1020_30F0_0000_0000},
        {8'h8F, 8'h3C, 64'hFFFE_0102_8081_7F01},
        {8'h0F, 8'h12, 64'hC0C1_0000_0000_0000},
        {8'h81, 8'hFF, 64'hFF00_0000_0000_0000},
        {8'h00, 8'h05, 64'h0102_0304_0506_0708},
        {8'h0C, 8'h05, 64'hAA55_AA55_AA55_AA55},
        {8'h88, 8'hC1, 64'hFFFF_FFFF_FFFF_FFFF}
    };

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic int ref_len(input logic [7:0] c, input logic [7:0] p);
        if (c[3:0] == 4'hF) begin
            case (p[5:4])
                2'b10:   return 4;
                2'b11:   return 8;
                default: return 2;
            endcase
        end
        if (c[3:0] == 0 || c[3:0] > 8) return 8;
        return int'(c[3:0]);
    endfunction

    function automatic bit ref_oob(input logic [7:0] c);
        return c[3:0] != 4'hF && (c[3:0] == 0 || c[3:0] > 8);
    endfunction

    function automatic logic [7:0] ref_sum(input logic [7:0] c, input logic [7:0] p,
                                           input logic [63:0] d, input int n);
        int s = c[7] ? int'(p) : 0;
        for (int i = 0; i < n; i++) begin
            s = s + int'(d[8*(7-i) +: 8]);
            if (s > 255) s = s - 255;
        end
        return s[7:0];
    endfunction

    task automatic write_cfg(input logic [7:0] v);
        @(negedge clk); cfg_we = 1'b1; cfg_wdata = v;
        @(negedge clk); cfg_we = 1'b0;
    endtask

    task automatic pulse_start(input bit with_byte, input logic [7:0] b);
        @(negedge clk); start = 1'b1; byte_valid = with_byte; byte_data = b;
        @(negedge clk); start = 1'b0; byte_valid = 1'b0;
    endtask

    task automatic send(input logic [7:0] b, input bit last);
        @(negedge clk); byte_valid = 1'b1; byte_data = b; byte_last = last;
        @(negedge clk); byte_valid = 1'b0; byte_last = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(cfg_rdata == 8'h00, "R1 cfg reset", cfg_rdata, 0);
        chk(run_sum == 8'h00, "R1 sum reset", run_sum, 0);
        chk(done == 1'b0 && chk_match == 1'b0, "R9 idle after reset", done, 0);
        rst_n = 1'b1;

        // R1 unused bits masked
        write_cfg(8'hFF);
        chk(cfg_rdata == 8'h8F, "R1 readback mask", cfg_rdata, 8'h8F);

        // Table walk: R2 R3 R4 R5 R6 R7 R8 R9
        for (int v = 0; v < NV; v++) begin
            logic [7:0]  c = VEC[v][79:72];
            logic [7:0]  p = VEC[v][71:64];
            logic [63:0] d = VEC[v][63:0];
            int          n = ref_len(c, p);
            logic [7:0]  s = ref_sum(c, p, d, n);
            write_cfg(c);
            pid = p;
            @(negedge clk);
            chk(int'(data_len) == n, "R2 R3 R4 data_len", data_len, n);
            chk(size_oob == ref_oob(c), "R4 size_oob", size_oob, ref_oob(c));
            pulse_start(1'b0, 8'h00);
            chk(run_sum == (c[7] ? p : 8'h00), "R5 R6 seed", run_sum, c[7] ? p : 0);
            for (int i = 0; i < n; i++) send(d[8*(7-i) +: 8], 1'b0);
            chk(run_sum == s, "R7 sum", run_sum, s);
            chk(csum_out == ~s, "R7 inverted", csum_out, ~s);
            send(~s, 1'b1);
            chk(done == 1'b1, "R9 done high", done, 1);
            chk(chk_match == 1'b1, "R8 match", chk_match, 1);
            @(negedge clk);
            chk(done == 1'b0, "R9 done one cycle", done, 0);
            chk(chk_match == 1'b1, "R8 match held", chk_match, 1);
        end

        // R7 explicit carry fold: FF + 02 = 0x02
        write_cfg(8'h02);
        pulse_start(1'b0, 8'h00);
        send(8'hFF, 1'b0);
        send(8'h02, 1'b0);
        chk(run_sum == 8'h02, "R7 end-around carry", run_sum, 2);

        // R8 wrong checksum
        send(8'h00, 1'b1);
        chk(done == 1'b1 && chk_match == 1'b0, "R8 mismatch", chk_match, 0);

        // R11 bytes while idle are ignored
        send(8'h33, 1'b0);
        chk(run_sum == 8'h02, "R11 idle byte ignored", run_sum, 2);
        chk(done == 1'b0, "R11 no done when idle", done, 0);

        // R10 early last on a data byte
        write_cfg(8'h04);
        pulse_start(1'b0, 8'h00);
        send(8'h10, 1'b0);
        send(8'h20, 1'b1);
        chk(done == 1'b1, "R10 early end done", done, 1);
        chk(chk_match == 1'b0, "R10 early end no match", chk_match, 0);
        chk(run_sum == 8'h30, "R10 last byte added", run_sum, 8'h30);
        send(8'hCF, 1'b0);
        chk(run_sum == 8'h30 && done == 1'b0, "R10 frame closed", run_sum, 8'h30);

        // R12 start wins over a byte in the same cycle
        write_cfg(8'h01);
        pulse_start(1'b1, 8'h77);
        chk(run_sum == 8'h00, "R12 byte not added", run_sum, 0);
        send(8'h05, 1'b0);
        send(8'hFA, 1'b1);
        chk(done == 1'b1 && chk_match == 1'b1, "R12 byte not counted", chk_match, 1);

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule